// File: doc/BRIEF.md
# Chained Power-Driver Update Sequencer

This block sits on the host side of two daisy-chained 8-bit serial-in, latched-output power driver registers. A 16-bit status word handed over with a valid/ready handshake is shifted out most significant bit first on a serial data line, clocked by a generated shift clock. Each half phase of that clock is a programmable number of system clock cycles. Only after the sixteenth shift clock has fallen does the block raise the register clock once, so both driver registers update their outputs together.

The active-low output enable line is also a global dimmer. A free-running counter of 2^PWM_W system clocks holds it low for `duty` cycles of every period. Duty zero keeps every load off. Leaving reset, the block first holds the active-low clear line low and keeps the loads off. It accepts no word until that clear phase is over.

Top module: `driverChainCtrl`

## Requirements
- R1: After reset is released, `clrN` stays low for at least HALF_TICKS clock cycles. No shift-clock edge occurs and `wordReady` stays low while `clrN` is low.
- R2: Each accepted word produces exactly 16 rising edges of `shiftClk`, followed by exactly one pulse on `latchClk`. That pulse rises only after the 16th shift-clock high phase has ended, and the two clocks are never high together.
- R3: Bits leave most significant first. A receiver that shifts `serData` in at its bit 0 on each `shiftClk` rise and copies on the `latchClk` rise therefore holds the accepted word exactly: bit 15 in the far register's last stage, bit 0 in the near register's first stage.
- R4: `serData` is stable for at least HALF_TICKS cycles before every `shiftClk` rise and does not change while `shiftClk` is high.
- R5: Every high phase of `shiftClk` and of `latchClk` lasts exactly HALF_TICKS clock cycles.
- R6: `wordReady` is high only when no transfer is running, `latchClk` is low and the clear phase is over. A word is taken on a cycle with `wordValid` and `wordReady` both high. Changes on `wordIn` after acceptance do not affect the shifted word.
- R7: `shiftClk` and `latchClk` idle low, and neither toggles while no word is accepted.
- R8: Over any 256 consecutive cycles with constant `duty`, `outEnN` is low for exactly `duty` cycles (PWM_W = 8). With `duty` = 0 it is high one cycle later and stays high.
- R9: `outEnN` is high whenever `clrN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wordIn | input | WORD_W | Status word; 1 turns a load on |
| wordValid | input | 1 | Word offered |
| wordReady | output | 1 | Block can take a word |
| duty | input | PWM_W | Output-enable low cycles per period |
| serData | output | 1 | Serial data to the first driver register |
| shiftClk | output | 1 | Shift clock of the chain |
| latchClk | output | 1 | Register (latch) clock of the chain |
| clrN | output | 1 | Chain clear, active low |
| outEnN | output | 1 | Output enable / dimming, active low |

## Verification
A wrong bit counter shows up at the port as a shift-rise count other than 16 before the latch pulse. That error is visible at the end of the first transfer, and the word seen by a receiver model then differs from the one sent. A wrong phase counter shows up as a high phase whose length is not HALF_TICKS, or as data moving inside a high phase, at the first clock edge where it happens. A broken dimming comparator is visible within one 256-cycle window as a wrong count of low output-enable cycles. A gating slip in the handshake shows as `wordReady` high while a clock line is high or while the clear line is asserted.

// File: rtl/chainPkg.sv
`timescale 1ns/1ps
package chainPkg;

  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_IDLE,
    ST_SHIFT_LO,
    ST_SHIFT_HI,
    ST_LATCH_LO,
    ST_LATCH_HI
  } chainState_t;

  typedef struct packed {
    logic load;     // capture wordIn into the shift register
    logic shift;    // advance to the next bit
    logic sclkLvl;  // shift clock level for the next cycle
    logic lclkLvl;  // latch clock level for the next cycle
    logic clrAct;   // clear phase active
  } chainStrobe_t;

endpackage

// File: rtl/chainSeqCtrl.sv
`timescale 1ns/1ps
module chainSeqCtrl
  import chainPkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int HALF_TICKS = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wordValid,
  input  logic         lineBusy,
  output logic         wordReady,
  output chainStrobe_t strobe
);

  localparam int TICK_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam int BIT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(HALF_TICKS - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);

  chainState_t       state;
  logic [TICK_W-1:0] tickCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              phaseDone;
  logic              accept;

  assign phaseDone = (tickCnt == LAST_TICK);
  assign wordReady = (state == ST_IDLE) && !lineBusy;
  assign accept    = wordValid && wordReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_CLEAR;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      case (state)
        ST_CLEAR: begin
          if (phaseDone) begin
            state   <= ST_IDLE;
            tickCnt <= '0;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_SHIFT_LO;
            tickCnt <= '0;
            bitCnt  <= '0;
          end
        end
        ST_SHIFT_LO: begin
          if (phaseDone) begin
            state   <= ST_SHIFT_HI;
            tickCnt <= '0;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_SHIFT_HI: begin
          if (phaseDone) begin
            tickCnt <= '0;
            if (bitCnt == LAST_BIT) begin
              state <= ST_LATCH_LO;
            end else begin
              bitCnt <= bitCnt + 1'b1;
              state  <= ST_SHIFT_LO;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_LATCH_LO: begin
          if (phaseDone) begin
            state   <= ST_LATCH_HI;
            tickCnt <= '0;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_LATCH_HI: begin
          if (phaseDone) begin
            state   <= ST_IDLE;
            tickCnt <= '0;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: begin
          state   <= ST_CLEAR;
          tickCnt <= '0;
        end
      endcase
    end
  end

  always_comb begin
    strobe.load    = accept;
    strobe.shift   = (state == ST_SHIFT_LO) && (tickCnt == '0) && (bitCnt != '0);
    strobe.sclkLvl = (state == ST_SHIFT_HI);
    strobe.lclkLvl = (state == ST_LATCH_HI);
    strobe.clrAct  = (state == ST_CLEAR);
  end

endmodule

// File: rtl/chainDatapath.sv
`timescale 1ns/1ps
module chainDatapath
  import chainPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int PWM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  chainStrobe_t      strobe,
  input  logic [WORD_W-1:0] wordIn,
  input  logic [PWM_W-1:0]  duty,
  output logic              serData,
  output logic              shiftClk,
  output logic              latchClk,
  output logic              clrN,
  output logic              outEnN
);

  logic [WORD_W-1:0] shReg;
  logic [PWM_W-1:0]  pwmCnt;
  logic              sclkQ;
  logic              lclkQ;
  logic              clrNQ;
  logic              outEnQ;

  // Serial word: most significant bit drives the line first.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strobe.load) begin
      shReg <= wordIn;
    end else if (strobe.shift) begin
      shReg <= {shReg[WORD_W-2:0], 1'b0};
    end
  end

  // Registered line levels so every pin changes only on a clock edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
      lclkQ <= 1'b0;
      clrNQ <= 1'b0;
    end else begin
      sclkQ <= strobe.sclkLvl;
      lclkQ <= strobe.lclkLvl;
      clrNQ <= !strobe.clrAct;
    end
  end

  // Free-running dimming counter; enable low while count is below duty.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmCnt <= '0;
      outEnQ <= 1'b1;
    end else begin
      pwmCnt <= pwmCnt + 1'b1;
      outEnQ <= strobe.clrAct || (pwmCnt >= duty);
    end
  end

  assign serData  = shReg[WORD_W-1];
  assign shiftClk = sclkQ;
  assign latchClk = lclkQ;
  assign clrN     = clrNQ;
  assign outEnN   = outEnQ;

endmodule

// File: rtl/driverChainCtrl.sv
`timescale 1ns/1ps
module driverChainCtrl
  import chainPkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int HALF_TICKS = 8,
  parameter int PWM_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              wordValid,
  output logic              wordReady,
  input  logic [PWM_W-1:0]  duty,
  output logic              serData,
  output logic              shiftClk,
  output logic              latchClk,
  output logic              clrN,
  output logic              outEnN
);

  chainStrobe_t strobe;
  logic         lineBusy;

  // A word waits until the latch pulse has dropped and clear is released.
  assign lineBusy = latchClk || !clrN;

  chainSeqCtrl #(
    .WORD_W     (WORD_W),
    .HALF_TICKS (HALF_TICKS)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wordValid (wordValid),
    .lineBusy  (lineBusy),
    .wordReady (wordReady),
    .strobe    (strobe)
  );

  chainDatapath #(
    .WORD_W (WORD_W),
    .PWM_W  (PWM_W)
  ) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wordIn   (wordIn),
    .duty     (duty),
    .serData  (serData),
    .shiftClk (shiftClk),
    .latchClk (latchClk),
    .clrN     (clrN),
    .outEnN   (outEnN)
  );

endmodule

// File: rtl/chainCheck.sv
`timescale 1ns/1ps
module chainCheck #(
  parameter int HALF_TICKS = 8,
  parameter int PWM_W      = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wordReady,
  input logic [PWM_W-1:0] duty,
  input logic             serData,
  input logic             shiftClk,
  input logic             latchClk,
  input logic             clrN,
  input logic             outEnN
);

  logic [15:0] sRun;
  logic [15:0] lRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sRun <= '0;
      lRun <= '0;
    end else begin
      sRun <= shiftClk ? sRun + 16'd1 : 16'd0;
      lRun <= latchClk ? lRun + 16'd1 : 16'd0;
    end
  end

  assert_clear_first_R1: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |-> (!wordReady && !shiftClk && !latchClk));

  assert_clocks_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(shiftClk && latchClk));

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (shiftClk && $past(shiftClk)) |-> $stable(serData));

  assert_shift_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!shiftClk && sRun != 16'd0) |-> (sRun == 16'(HALF_TICKS)));

  assert_latch_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!latchClk && lRun != 16'd0) |-> (lRun == 16'(HALF_TICKS)));

  assert_ready_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    wordReady |-> (!shiftClk && !latchClk && clrN));

  assert_duty_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (duty == '0) |=> outEnN);

  assert_off_in_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |-> outEnN);

endmodule

bind driverChainCtrl chainCheck #(
  .HALF_TICKS (HALF_TICKS),
  .PWM_W      (PWM_W)
) i_chainCheck (
  .clk       (clk),
  .rstN      (rstN),
  .wordReady (wordReady),
  .duty      (duty),
  .serData   (serData),
  .shiftClk  (shiftClk),
  .latchClk  (latchClk),
  .clrN      (clrN),
  .outEnN    (outEnN)
);

// File: tb/test_driverChainCtrl.sv
`timescale 1ns/1ps
module test_driverChainCtrl;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] wordIn = '0;
  logic        wordValid = 1'b0;
  logic        wordReady;
  logic [7:0]  duty = 8'd255;
  logic        serData;
  logic        shiftClk;
  logic        latchClk;
  logic        clrN;
  logic        outEnN;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  driverChainCtrl i_driverChainCtrl (
    .clk (clk), .rstN (rstN), .wordIn (wordIn), .wordValid (wordValid),
    .wordReady (wordReady), .duty (duty), .serData (serData),
    .shiftClk (shiftClk), .latchClk (latchClk), .clrN (clrN), .outEnN (outEnN)
  );

  // Receiver model of the two chained registers plus line timing monitors.
  logic [15:0] chainModel = '0;
  logic [15:0] storeReg = '0;
  int shiftRises = 0, latchRises = 0, risesAtLatch = 0;
  int holdErr = 0, setupErr = 0, widthErr = 0, readyErr = 0;
  int sHigh = 0, lHigh = 0, serStable = 0;
  logic prevS = 0, prevL = 0, prevSer = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (serData != prevSer) serStable = 0; else serStable++;
      if (shiftClk && !prevS) begin
        if (serStable < HALF) setupErr++;
        chainModel = {chainModel[14:0], serData};
        shiftRises++;
      end
      if (shiftClk && prevS && serData != prevSer) holdErr++;
      if (latchClk && !prevL) begin
        storeReg = chainModel;
        latchRises++;
        risesAtLatch = shiftRises;
      end
      if (shiftClk) sHigh++;
      else begin
        if (prevS && sHigh != HALF) widthErr++;
        sHigh = 0;
      end
      if (latchClk) lHigh++;
      else begin
        if (prevL && lHigh != HALF) widthErr++;
        lHigh = 0;
      end
      if (wordReady && (shiftClk || latchClk || !clrN)) readyErr++;
    end
    prevS = shiftClk;
    prevL = latchClk;
    prevSer = serData;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic testReset();
    int lowCnt = 0;
    repeat (3) @(negedge clk);
    check(clrN == 0 && shiftClk == 0 && latchClk == 0, "R1 reset lines", {clrN, shiftClk, latchClk}, 0);
    check(outEnN == 1, "R9 off during reset", outEnN, 1);
    check(wordReady == 0, "R1 not ready in reset", wordReady, 0);
    @(posedge clk); #1 rstN = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (clrN) break;
      lowCnt++;
      check(outEnN == 1, "R9 off while clear", outEnN, 1);
      check(wordReady == 0 && shiftClk == 0, "R1 quiet while clear", {wordReady, shiftClk}, 0);
    end
    check(lowCnt >= HALF, "R1 clear length", lowCnt, HALF);
    check(clrN == 1, "R1 clear released", clrN, 1);
  endtask

  task automatic transfer(input logic [15:0] w, input bit scramble);
    int s0 = shiftRises, l0 = latchRises;
    int guard = 0;
    @(negedge clk);
    while (!wordReady && guard < 1000) begin @(negedge clk); guard++; end
    @(posedge clk); #1 wordIn = w; wordValid = 1'b1;
    @(posedge clk); #1 wordValid = 1'b0;
    if (scramble) wordIn = ~w;
    @(negedge clk);
    check(wordReady == 0, "R6 busy after accept", wordReady, 0);
    guard = 0;
    while (!wordReady && guard < 2000) begin @(negedge clk); guard++; end
    check(storeReg == w, scramble ? "R6 late input ignored" : "R3 word order", storeReg, w);
    check(shiftRises - s0 == 16, "R2 shift count", shiftRises - s0, 16);
    check(latchRises - l0 == 1, "R2 one latch pulse", latchRises - l0, 1);
    check(risesAtLatch == s0 + 16, "R2 latch after last shift", risesAtLatch - s0, 16);
  endtask

  task automatic testIdle();
    int s0 = shiftRises, l0 = latchRises;
    wordIn = 16'h5A5A;
    repeat (200) @(negedge clk);
    check(shiftRises == s0 && latchRises == l0, "R7 no edges when idle", shiftRises - s0, 0);
    check(shiftClk == 0 && latchClk == 0, "R7 idle low", {shiftClk, latchClk}, 0);
  endtask

  task automatic testPwm(input logic [7:0] d);
    int lows = 0;
    @(posedge clk); #1 duty = d;
    repeat (300) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (!outEnN) lows++;
    end
    check(lows == int'(d), "R8 dimming low count", lows, d);
  endtask

  task automatic testTiming();
    check(holdErr == 0, "R4 data hold", holdErr, 0);
    check(setupErr == 0, "R4 data setup", setupErr, 0);
    check(widthErr == 0, "R5 phase width", widthErr, 0);
    check(readyErr == 0, "R6 ready gating", readyErr, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testReset();
    transfer(16'hA5C3, 0);
    transfer(16'hFFFF, 0);
    transfer(16'h0000, 0);
    transfer(16'h8001, 0);
    transfer(16'h1234, 1);
    testIdle();
    testPwm(8'd0);
    testPwm(8'd1);
    testPwm(8'd128);
    testPwm(8'd255);
    testTiming();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule